// File: doc/BRIEF.md
# Serial target front end with suspend

This block is the bit-level front end of a memory-style serial target. It sits between the four serial pins (clock, active-low select, data in, active-low suspend) and a command engine in the core clock domain. All serial pins are first passed through a synchronizer and then sampled on the core clock, so the block itself contains no serial-clock flip-flops. It accepts both clock polarities in which data is captured on the rising serial clock edge: mode 0, where the clock rests low, and mode 3, where it rests high. Every byte is captured and sent most significant bit first.

Each select-low period is one transaction. Every completed byte goes to the engine with a one-cycle strobe and its position in the transaction, so the engine can treat position zero as the opcode. The engine returns a transmit byte and a drive request. The block loads these at the falling clock edge that opens the next byte, then shifts them out on the data output with a separate output enable, so the pad can be tristated. A raised select is reported with a one-cycle event. When the engine rejects the opcode, the interface stays silent until select has been raised and lowered again. Pulling the suspend input low while the clock is low freezes the transaction at its current bit. The transaction resumes from the same bit once suspend is high again while the clock is low.

Top module: `spi_fe_top`

## Requirements
- R1: After reset `spi_so`, `spi_so_oe`, `rx_valid` and `cs_rise_evt` are all 0.
- R2: While selected and neither suspended nor locked, each rising serial clock edge shifts `spi_si` into the receive register, MSB first. After every eighth such edge, `rx_byte` carries the byte and `rx_valid` is high for exactly one core clock cycle.
- R3: Reception and transmission work in mode 0 (clock low while select falls) and in mode 3 (clock high while select falls). In both modes the rising edge samples and the falling edge changes the output.
- R4: At a counted falling clock edge with the bit count at zero, `tx_byte` and `tx_oe` are loaded. The MSB appears on `spi_so`, and each later counted falling edge moves the next lower bit out. `spi_so_oe` equals the loaded `tx_oe` while the block is selected, not suspended and not locked.
- R5: While `spi_cs_n` is high, clock and data activity produces no `rx_valid`, and `spi_so_oe` stays 0.
- R6: `rx_index` gives the position of the delivered byte in its transaction, starting at 0 after select falls. It counts up by one per byte and saturates at 2^IDX_W-1.
- R7: If `opcode_bad` is high in the cycle in which `rx_valid` is high with `rx_index` 0, no further byte is delivered and `spi_so_oe` stays 0 until `spi_cs_n` has gone high and then low again.
- R8: Suspend is entered only when `spi_hold_n` is low while the clock is low, and left only when `spi_hold_n` is high while the clock is low. A change of `spi_hold_n` while the clock is high takes effect at the next low clock.
- R9: While suspended, serial clock edges neither sample nor shift, `spi_so_oe` is 0, and the bit and byte positions are kept for the resume.
- R10: A rising select produces a one-cycle `cs_rise_evt` and discards any partial byte. The next transaction starts at bit 0 and byte index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_sck | input | 1 | Serial clock from the controller |
| spi_cs_n | input | 1 | Active-low select |
| spi_si | input | 1 | Serial data into the target |
| spi_hold_n | input | 1 | Active-low suspend request |
| spi_so | output | 1 | Serial data out of the target |
| spi_so_oe | output | 1 | Output enable for the data-out pad |
| rx_valid | output | 1 | One-cycle strobe: a byte was received |
| rx_byte | output | DATA_W | Received byte |
| rx_index | output | IDX_W | Position of the received byte in its transaction |
| cs_rise_evt | output | 1 | One-cycle strobe: select was raised |
| tx_byte | input | DATA_W | Byte the engine wants sent next |
| tx_drive | input | 1 | Drive request for the next byte |
| opcode_bad | input | 1 | Engine flag: the first byte is rejected |

## Verification
Full transactions are run in both clock polarities with bytes that differ from byte to byte. The engine model answers each byte with its value plus 0x11, so a bit slip, a wrong byte boundary or a polarity fault shows up on both the receive and the transmit side. A select raised after four bits, followed by a fresh transaction, shows whether partial bits are discarded. The suspend stimulus lowers and raises the suspend input while the clock is high and toggles the clock with garbage data in between, which shows the low-clock qualification and the frozen position apart. A rejected opcode followed by more bytes and a new transaction, and a ten-byte transaction with a three-bit index, cover the lockout and the index saturation.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;

  typedef struct packed {
    logic sck;
    logic cs_n;
    logic si;
    logic hold_n;
  } spi_pins_t;

  localparam spi_pins_t PINS_IDLE = '{sck: 1'b0, cs_n: 1'b1, si: 1'b0, hold_n: 1'b1};

  // Counter step that stops at lim.
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v >= lim) ? lim : v + 1;
  endfunction

  // Suspend state update: deselect clears it, a low clock lets it follow the pin.
  function automatic logic next_held(logic held, logic sck, logic hold_n, logic sel);
    if (!sel) return 1'b0;
    if (!sck) return !hold_n;
    return held;
  endfunction

endpackage

// File: rtl/spi_fe_sync.sv
module spi_fe_sync
  import spi_fe_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t d,
  output spi_pins_t q
);

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_st
    spi_pins_t r;
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= PINS_IDLE;
        else        r <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r <= PINS_IDLE;
        else        r <= g_st[g-1].r;
      end
    end
  end

  assign q = g_st[STAGES-1].r;

endmodule

// File: rtl/spi_fe_frame.sv
module spi_fe_frame
  import spi_fe_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  spi_pins_t pin_s,
  input  logic      rx_valid,
  input  logic      rx_first,
  input  logic      opcode_bad,
  output logic      sel,
  output logic      held,
  output logic      locked,
  output logic      bit_rise,
  output logic      bit_fall,
  output logic      cs_rise,
  output logic      cs_fall
);

  logic sck_d;
  logic cs_d;
  logic adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d <= 1'b0;
      cs_d  <= 1'b1;
    end else begin
      sck_d <= pin_s.sck;
      cs_d  <= pin_s.cs_n;
    end
  end

  assign sel     = ~pin_s.cs_n;
  assign cs_fall = cs_d & ~pin_s.cs_n;
  assign cs_rise = ~cs_d & pin_s.cs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held <= 1'b0;
    else        held <= next_held(held, pin_s.sck, pin_s.hold_n, sel);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    locked <= 1'b0;
    else if (cs_fall)                              locked <= 1'b0;
    else if (rx_valid && rx_first && opcode_bad)   locked <= 1'b1;
  end

  assign adv      = sel & ~held & ~locked;
  assign bit_rise = adv & pin_s.sck & ~sck_d;
  assign bit_fall = adv & ~pin_s.sck & sck_d;

endmodule

// File: rtl/spi_fe_rx.sv
module spi_fe_rx
  import spi_fe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bit_rise,
  input  logic              si,
  output logic [CNT_W-1:0]  bit_cnt,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  rx_index
);

  localparam int          LAST    = DATA_W - 1;
  localparam int unsigned IDX_MAX = (1 << IDX_W) - 1;

  logic [DATA_W-1:0] shreg;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_nx;
  logic              last_bit;

  assign shreg_nx = {shreg[DATA_W-2:0], si};
  assign last_bit = (bit_cnt == CNT_W'(LAST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      shreg    <= '0;
      idx_q    <= '0;
      rx_valid <= 1'b0;
      rx_byte  <= '0;
      rx_index <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (restart) begin
        bit_cnt <= '0;
        idx_q   <= '0;
      end else if (bit_rise) begin
        shreg <= shreg_nx;
        if (last_bit) begin
          bit_cnt  <= '0;
          rx_byte  <= shreg_nx;
          rx_valid <= 1'b1;
          rx_index <= idx_q;
          idx_q    <= IDX_W'(sat_inc(int'(idx_q), IDX_MAX));
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/spi_fe_tx.sv
module spi_fe_tx #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_fall,
  input  logic              bit_fall,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_drive,
  input  logic              drive_ok,
  output logic              so,
  output logic              so_oe
);

  logic [DATA_W-1:0] shreg;
  logic              oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      oe_q  <= 1'b0;
    end else if (cs_fall) begin
      shreg <= '0;
      oe_q  <= 1'b0;
    end else if (bit_fall) begin
      if (bit_cnt == '0) begin
        shreg <= tx_byte;
        oe_q  <= tx_drive;
      end else begin
        shreg <= {shreg[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign so    = shreg[DATA_W-1];
  assign so_oe = oe_q & drive_ok;

endmodule

// File: rtl/spi_fe_top.sv
module spi_fe_top
  import spi_fe_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sck,
  input  logic              spi_cs_n,
  input  logic              spi_si,
  input  logic              spi_hold_n,
  output logic              spi_so,
  output logic              spi_so_oe,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_byte,
  output logic [IDX_W-1:0]  rx_index,
  output logic              cs_rise_evt,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              tx_drive,
  input  logic              opcode_bad
);

  localparam int CNT_W = $clog2(DATA_W);

  spi_pins_t        pin_raw;
  spi_pins_t        pin_s;
  logic             sck_s;
  logic             sel;
  logic             held;
  logic             locked;
  logic             bit_rise;
  logic             bit_fall;
  logic             cs_rise;
  logic             cs_fall;
  logic             drive_ok;
  logic [CNT_W-1:0] bit_cnt;

  assign pin_raw = '{sck: spi_sck, cs_n: spi_cs_n, si: spi_si, hold_n: spi_hold_n};
  assign sck_s   = pin_s.sck;

  spi_fe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst_n (rst_n),
    .d   (pin_raw),
    .q   (pin_s)
  );

  spi_fe_frame u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_s      (pin_s),
    .rx_valid   (rx_valid),
    .rx_first   (rx_index == '0),
    .opcode_bad (opcode_bad),
    .sel        (sel),
    .held       (held),
    .locked     (locked),
    .bit_rise   (bit_rise),
    .bit_fall   (bit_fall),
    .cs_rise    (cs_rise),
    .cs_fall    (cs_fall)
  );

  spi_fe_rx #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (cs_rise | cs_fall),
    .bit_rise (bit_rise),
    .si       (pin_s.si),
    .bit_cnt  (bit_cnt),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_index (rx_index)
  );

  assign drive_ok = sel & ~held & ~locked;

  spi_fe_tx #(.DATA_W(DATA_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_fall  (cs_fall),
    .bit_fall (bit_fall),
    .bit_cnt  (bit_cnt),
    .tx_byte  (tx_byte),
    .tx_drive (tx_drive),
    .drive_ok (drive_ok),
    .so       (spi_so),
    .so_oe    (spi_so_oe)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cs_rise_evt <= 1'b0;
    else        cs_rise_evt <= cs_rise;
  end

endmodule

// File: rtl/spi_fe_chk.sv
module spi_fe_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sel,
  input logic             held,
  input logic             locked,
  input logic             sck_s,
  input logic [CNT_W-1:0] bit_cnt,
  input logic             rx_valid,
  input logic             so_oe,
  input logic             cs_rise_evt
);

  p_rx_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_desel_tri_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> !so_oe);

  p_lock_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (!rx_valid && !so_oe));

  p_hold_enter_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(held) |-> !$past(sck_s));

  p_hold_leave_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(held) |-> (!$past(sck_s) || !$past(sel)));

  p_hold_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (held && sel) |=> $stable(bit_cnt));

  p_hold_tri_r9: assert property (@(posedge clk) disable iff (!rst_n)
    held |-> !so_oe);

  p_csrise_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_rise_evt |-> (bit_cnt == '0 && !rx_valid));

endmodule

bind spi_fe_top spi_fe_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sel         (sel),
  .held        (held),
  .locked      (locked),
  .sck_s       (sck_s),
  .bit_cnt     (bit_cnt),
  .rx_valid    (rx_valid),
  .so_oe       (spi_so_oe),
  .cs_rise_evt (cs_rise_evt)
);

// File: tb/spi_fe_top_tb_top.sv
module spi_fe_top_tb_top;

  localparam int H       = 10;
  localparam int IDX_W   = 3;
  localparam int IDX_MAX = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sck = 1'b0;
  logic       spi_cs_n = 1'b1;
  logic       spi_si = 1'b0;
  logic       spi_hold_n = 1'b1;
  logic       spi_so;
  logic       spi_so_oe;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic [IDX_W-1:0] rx_index;
  logic       cs_rise_evt;
  logic [7:0] tx_byte = 8'h00;
  logic       tx_drive = 1'b0;
  logic       opcode_bad;

  int checks = 0;
  int failures = 0;
  int rx_seen = 0;
  int cs_rise_seen = 0;
  int cs_hi_cnt = 0;
  bit done = 0;
  int         exp_idx_q[$];
  logic [7:0] exp_byte_q[$];

  always #10 clk = ~clk;

  spi_fe_top #(.DATA_W(8), .IDX_W(IDX_W), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rst_n (rst_n),
    .spi_sck (spi_sck), .spi_cs_n (spi_cs_n), .spi_si (spi_si), .spi_hold_n (spi_hold_n),
    .spi_so (spi_so), .spi_so_oe (spi_so_oe),
    .rx_valid (rx_valid), .rx_byte (rx_byte), .rx_index (rx_index),
    .cs_rise_evt (cs_rise_evt),
    .tx_byte (tx_byte), .tx_drive (tx_drive), .opcode_bad (opcode_bad)
  );

  // Engine model: 0xFF as first byte is rejected; otherwise answer with byte + 0x11.
  assign opcode_bad = rx_valid && (rx_index == '0) && (rx_byte == 8'hFF);

  task automatic fail(string req, string what, int act, int exp);
    failures++;
    $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
  endtask

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) fail(req, what, act, exp);
  endtask

  // Reference monitor, evaluated every clock away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_seen++;
        checks++;
        if (exp_byte_q.size() == 0) begin
          fail("R2", "unexpected rx_valid byte", int'(rx_byte), -1);
        end else begin
          int ei;
          logic [7:0] eb;
          ei = exp_idx_q.pop_front();
          eb = exp_byte_q.pop_front();
          if (rx_byte != eb) fail("R2", "rx_byte", int'(rx_byte), int'(eb));
          if (int'(rx_index) != ei) fail("R6", "rx_index", int'(rx_index), ei);
        end
        if (!opcode_bad) begin
          tx_byte  = rx_byte + 8'h11;
          tx_drive = 1'b1;
        end
      end
      if (cs_rise_evt) begin
        cs_rise_seen++;
        tx_drive = 1'b0;
      end
      if (spi_cs_n) cs_hi_cnt++; else cs_hi_cnt = 0;
      if (spi_cs_n && cs_hi_cnt > 6 && spi_so_oe) fail("R5", "so_oe while deselected", 1, 0);
    end
  end

  task automatic wait_h();
    repeat (H) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic so_v, output logic oe_v);
    spi_sck = 1'b0;
    spi_si  = b;
    wait_h();
    so_v = spi_so;
    oe_v = spi_so_oe;
    spi_sck = 1'b1;
    wait_h();
  endtask

  task automatic send_byte(input logic [7:0] mo, input bit expect_rx, input int idx,
                           input bit exp_oe, input logic [7:0] exp_so, input string req);
    logic [7:0] sv;
    logic [7:0] ov;
    if (expect_rx) begin
      exp_idx_q.push_back((idx > IDX_MAX) ? IDX_MAX : idx);
      exp_byte_q.push_back(mo);
    end
    for (int i = 7; i >= 0; i--) bit_x(mo[i], sv[i], ov[i]);
    if (exp_oe) begin
      chk(req, "so byte", int'(sv), int'(exp_so));
      chk(req, "so_oe per bit", int'(ov), 8'hFF);
    end else begin
      chk(req, "so_oe off per bit", int'(ov), 0);
    end
  endtask

  task automatic begin_frame(input bit m3);
    spi_sck = m3;
    wait_h();
    spi_cs_n = 1'b0;
    wait_h();
  endtask

  task automatic end_frame(input bit m3);
    if (!m3) begin
      spi_sck = 1'b0;
      wait_h();
    end
    spi_cs_n = 1'b1;
    wait_h();
    wait_h();
  endtask

  task automatic frame(input bit m3, input int n, input logic [7:0] seed,
                       input logic [7:0] step, input string req);
    logic [7:0] b;
    logic [7:0] prev;
    prev = 8'h00;
    begin_frame(m3);
    for (int k = 0; k < n; k++) begin
      b = seed + 8'(k) * step;
      send_byte(b, 1'b1, k, k > 0, prev + 8'h11, req);
      prev = b;
    end
    end_frame(m3);
    chk(req, "rx queue drained", exp_byte_q.size(), 0);
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fail("WATCHDOG", "run did not finish", 0, 1);
    report();
  end

  initial begin
    int seen0;
    int rise0;
    logic [7:0] sv;
    logic [7:0] ov;
    logic junk_s;
    logic junk_o;

    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", "so_oe after reset", int'(spi_so_oe), 0);
    chk("R1", "so after reset", int'(spi_so), 0);
    chk("R1", "rx_valid after reset", int'(rx_valid), 0);
    chk("R1", "cs_rise_evt after reset", int'(cs_rise_evt), 0);

    // R5: activity while deselected is ignored
    seen0 = rx_seen;
    ov = 8'h00;
    for (int i = 0; i < 8; i++) begin
      bit_x(1'b1, junk_s, ov[i]);
    end
    spi_sck = 1'b0;
    wait_h();
    chk("R5", "rx bytes while deselected", rx_seen - seen0, 0);
    chk("R5", "so_oe while deselected", int'(ov), 0);

    // R2 R3 R4 R6: mode 0 transaction
    frame(1'b0, 4, 8'h03, 8'hA2, "R3_mode0_R2_R4");
    // R3: mode 3 transaction
    frame(1'b1, 3, 8'h5A, 8'h69, "R3_mode3");

    // R10: select raised after four bits, then a fresh transaction
    begin_frame(1'b0);
    send_byte(8'h12, 1'b1, 0, 1'b0, 8'h00, "R10");
    rise0 = cs_rise_seen;
    for (int i = 0; i < 4; i++) bit_x(i[0], junk_s, junk_o);
    end_frame(1'b0);
    chk("R10", "cs_rise_evt count", cs_rise_seen - rise0, 1);
    chk("R10", "partial byte dropped", exp_byte_q.size(), 0);
    frame(1'b0, 2, 8'h34, 8'h22, "R10_restart");

    // R8 R9: suspend entered and left only with the clock low
    begin_frame(1'b0);
    send_byte(8'h20, 1'b1, 0, 1'b0, 8'h00, "R9");
    exp_idx_q.push_back(1);
    exp_byte_q.push_back(8'h9C);
    for (int i = 7; i >= 5; i--) bit_x(sv[0] ^ sv[0] ^ 8'h9C >> i, sv[i], ov[i]);
    spi_hold_n = 1'b0;
    wait_h();
    chk("R8", "no suspend while clock high", int'(spi_so_oe), 1);
    spi_sck = 1'b0;
    wait_h();
    chk("R9", "so_oe off while suspended", int'(spi_so_oe), 0);
    spi_si = 1'b1;
    spi_sck = 1'b1;
    wait_h();
    spi_hold_n = 1'b1;
    wait_h();
    chk("R8", "still suspended while clock high", int'(spi_so_oe), 0);
    spi_si = 1'b0;
    spi_sck = 1'b0;
    wait_h();
    chk("R8", "resumed with clock low", int'(spi_so_oe), 1);
    for (int i = 4; i >= 0; i--) bit_x(sv[0] ^ sv[0] ^ 8'h9C >> i, sv[i], ov[i]);
    chk("R9", "so byte across suspend", int'(sv), 8'h31);
    chk("R9", "so_oe bits across suspend", int'(ov), 8'hFF);
    send_byte(8'h00, 1'b1, 2, 1'b1, 8'hAD, "R9_after_resume");
    end_frame(1'b0);
    chk("R9", "rx queue drained", exp_byte_q.size(), 0);

    // R7: rejected opcode locks the interface until a new select
    begin_frame(1'b0);
    send_byte(8'hFF, 1'b1, 0, 1'b0, 8'h00, "R7");
    seen0 = rx_seen;
    send_byte(8'h11, 1'b0, 0, 1'b0, 8'h00, "R7");
    send_byte(8'h22, 1'b0, 0, 1'b0, 8'h00, "R7");
    end_frame(1'b0);
    chk("R7", "bytes delivered while locked", rx_seen - seen0, 0);
    frame(1'b0, 2, 8'h05, 8'h01, "R7_recovery");

    // R6: index saturation with a three-bit index
    frame(1'b1, 10, 8'h10, 8'h07, "R6_saturation");

    report();
  end

endmodule